// File: doc/BRIEF.md
# Dual-Rail Word Checker with Locking Alarm

This block is one clocked stage of a protected datapath. Every logical bit of a word arrives on two wires, called rail A and rail B. On each clock edge the stage sorts every pair into one of four kinds: a zero, a one, an empty slot, or a fault. When every pair carries a value, the stage turns the word into plain binary, stores it, shows a one-cycle valid pulse, and sends the word on again in two-wire form. Between two words the sender must leave every pair empty for at least one cycle. A different complete word that comes without that gap is refused and marked.

The both-rails-high code is not treated as a fault to be put up with. The stage uses it on purpose as an alarm. If any input pair shows that code, or the tamper input is high at a clock edge, the stage enters an alarm state that it cannot leave by itself. In that state it drives every output pair to both-high, holds the binary output at zero, and asks the processor for a reset. Only the synchronous power-on reset clears the alarm.

Top module: `dual_rail_guard`

## Requirements
- R1: A pair with rail A low and rail B high is a 0, and rail A high with rail B low is a 1. When every pair is a 0 or a 1 and a word may be accepted, then after the next edge `word_o` holds the decoded word (bit i taken from pair i), `word_vld_o` is high for exactly that one cycle, `out_a_o` equals the word and `out_b_o` equals its inverse.
- R2: Both rails low is the empty (spacer) code. If any pair is empty, no word is accepted. `word_vld_o` stays low, `word_o` keeps its value, and both output rails are all zeros.
- R3: After a word is accepted, no further word is accepted until one cycle in which every input pair is empty. A complete word that differs from the stored word and arrives before that cycle raises `order_err_o` for one cycle and is dropped. The same word held steady raises nothing.
- R4: Both rails high on any input pair at a clock edge latches the alarm at that edge.
- R5: `tamper_i` high at a clock edge latches the alarm at that edge. It takes priority over a complete word in the same cycle, so that word is not accepted.
- R6: While the alarm is latched, every bit of `out_a_o` and `out_b_o` is 1, `word_o` is zero, `word_vld_o` and `order_err_o` are low, and `rst_req_o` is high.
- R7: Once latched, the alarm stays latched whatever the inputs do. Only `rst_n` sampled low clears it.
- R8: Flipping a single rail of a valid word never produces a valid pulse with a wrong value. A flip that gives both-high raises the alarm, and a flip that gives both-low leaves the word incomplete.
- R9: After reset, `word_o` is zero, the valid and order-error flags are low, both output rails are all zeros, `rst_req_o` is low, and the first complete word is accepted without a spacer before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| rail_a_i | input | WIDTH | Rail A of each input pair |
| rail_b_i | input | WIDTH | Rail B of each input pair |
| tamper_i | input | 1 | Tamper sensor; high forces the alarm |
| word_o | output | WIDTH | Last accepted word in binary, zero in alarm |
| word_vld_o | output | 1 | One-cycle pulse when a word is accepted |
| order_err_o | output | 1 | One-cycle pulse when a new word arrives without a spacer |
| out_a_o | output | WIDTH | Rail A of the output pairs |
| out_b_o | output | WIDTH | Rail B of the output pairs |
| rst_req_o | output | 1 | Reset request to the processor; high while the alarm is latched |

## Verification
Two events can fall in the same cycle: a word completing and the alarm tripping. The bench creates this overlap in two ways. In the first, tamper is raised in the same cycle that a fully valid word is presented. In the second, one rail of an otherwise complete word is flipped so that one pair reads both-high. In both cases the check passes only if, after that edge, no valid pulse appears, the binary output is zero, the output pairs are all both-high, and the reset request is high. Random runs mix words, spacers, partial words and out-of-order words, and a reference model in the bench predicts every output in each cycle.

// File: rtl/dual_rail_guard_pkg.sv
// Shared definitions for the dual-rail checker.
// A pair is packed as {rail_a, rail_b}.
package dual_rail_guard_pkg;

    typedef enum logic [1:0] {
        PAIR_EMPTY = 2'b00,   // spacer, no data
        PAIR_ZERO  = 2'b01,   // rail A low, rail B high
        PAIR_ONE   = 2'b10,   // rail A high, rail B low
        PAIR_FAULT = 2'b11    // both high: alarm code
    } pair_code_e;

endpackage

// File: rtl/dual_rail_pair_class.sv
// Sorts every input pair into data, empty or fault.
// Assumes the rails are already synchronous to clk. The logic is purely combinational.
module dual_rail_pair_class
    import dual_rail_guard_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] rail_a_i,
    input  logic [WIDTH-1:0] rail_b_i,
    output logic [WIDTH-1:0] is_data_o,
    output logic [WIDTH-1:0] is_empty_o,
    output logic [WIDTH-1:0] is_fault_o
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_pair
        pair_code_e code;

        // Classify one pair from its two rails.
        always_comb begin
            code          = pair_code_e'({rail_a_i[i], rail_b_i[i]});
            is_data_o[i]  = (code == PAIR_ZERO) || (code == PAIR_ONE);
            is_empty_o[i] = (code == PAIR_EMPTY);
            is_fault_o[i] = (code == PAIR_FAULT);
        end
    end

endmodule

// File: rtl/dual_rail_completion.sv
// Reduces the per-pair flags to word-level completion, spacer and fault signals.
// Assumes exactly one of the three flags is set for each pair.
module dual_rail_completion #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] is_data_i,
    input  logic [WIDTH-1:0] is_empty_i,
    input  logic [WIDTH-1:0] is_fault_i,
    output logic             all_data_o,
    output logic             all_empty_o,
    output logic             any_fault_o
);

    // Combine the flags of all pairs into word-level results.
    always_comb begin
        all_data_o  = &is_data_i;
        all_empty_o = &is_empty_i;
        any_fault_o = |is_fault_i;
    end

endmodule

// File: rtl/dual_rail_alarm_latch.sv
// Sticky alarm flag. It sets on any trip and clears only on synchronous reset.
// Assumes trip_i is already combined from every alarm source.
module dual_rail_alarm_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic trip_i,
    output logic alarm_o
);

    // Set the alarm on a trip and hold it until reset.
    always_ff @(posedge clk) begin
        if (!rst_n)      alarm_o <= 1'b0;
        else if (trip_i) alarm_o <= 1'b1;
    end

    // R7
    alarm_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_o |=> alarm_o);

    // R4 R5
    trip_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trip_i |=> alarm_o);

endmodule

// File: rtl/dual_rail_guard.sv
// Clocked dual-rail checker stage. It accepts complete words that come after a spacer,
// decodes them to binary, forwards them in two-wire form, and locks into an
// alarm state on a both-high pair or a tamper input.
// Assumes the inputs are synchronous to clk and rst_n is a synchronous power-on reset.
module dual_rail_guard #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] rail_a_i,
    input  logic [WIDTH-1:0] rail_b_i,
    input  logic             tamper_i,
    output logic [WIDTH-1:0] word_o,
    output logic             word_vld_o,
    output logic             order_err_o,
    output logic [WIDTH-1:0] out_a_o,
    output logic [WIDTH-1:0] out_b_o,
    output logic             rst_req_o
);

    localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};
    localparam logic [WIDTH-1:0] ALL_ZERO = '0;

    logic [WIDTH-1:0] is_data, is_empty, is_fault;
    logic             all_data, all_empty, any_fault;
    logic             alarm_q, trip, accept, ready_q;

    dual_rail_pair_class #(.WIDTH(WIDTH)) u_class (
        .rail_a_i   (rail_a_i),
        .rail_b_i   (rail_b_i),
        .is_data_o  (is_data),
        .is_empty_o (is_empty),
        .is_fault_o (is_fault)
    );

    dual_rail_completion #(.WIDTH(WIDTH)) u_done (
        .is_data_i   (is_data),
        .is_empty_i  (is_empty),
        .is_fault_i  (is_fault),
        .all_data_o  (all_data),
        .all_empty_o (all_empty),
        .any_fault_o (any_fault)
    );

    dual_rail_alarm_latch u_alarm (
        .clk     (clk),
        .rst_n   (rst_n),
        .trip_i  (trip),
        .alarm_o (alarm_q)
    );

    // Decide whether this cycle trips the alarm and whether it takes a word.
    always_comb begin
        trip   = any_fault | tamper_i;
        accept = all_data & ready_q & ~trip & ~alarm_q;
    end

    // Update the output register, the spacer-seen flag and the forwarded pairs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_o      <= ALL_ZERO;
            word_vld_o  <= 1'b0;
            order_err_o <= 1'b0;
            out_a_o     <= ALL_ZERO;
            out_b_o     <= ALL_ZERO;
            ready_q     <= 1'b1;
        end else if (alarm_q || trip) begin
            word_o      <= ALL_ZERO;
            word_vld_o  <= 1'b0;
            order_err_o <= 1'b0;
            out_a_o     <= ALL_ONES;
            out_b_o     <= ALL_ONES;
            ready_q     <= 1'b0;
        end else begin
            word_vld_o  <= accept;
            order_err_o <= all_data && !ready_q && (rail_a_i != word_o);
            out_a_o     <= accept ? rail_a_i  : ALL_ZERO;
            out_b_o     <= accept ? ~rail_a_i : ALL_ZERO;
            if (accept) begin
                word_o  <= rail_a_i;
                ready_q <= 1'b0;
            end else if (all_empty) begin
                ready_q <= 1'b1;
            end
        end
    end

    // Forward the alarm to the processor reset request.
    always_comb rst_req_o = alarm_q;

    // R6
    alarm_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_q |-> (out_a_o == ALL_ONES && out_b_o == ALL_ONES &&
                     word_o == ALL_ZERO && !word_vld_o && !order_err_o));

    // R1
    valid_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld_o |-> (out_a_o == word_o && out_b_o == ~word_o));

    // R3
    no_back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld_o |=> !word_vld_o);

    // R2 R8
    partial_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!all_data) |=> !word_vld_o);

    // R5
    tamper_blocks_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tamper_i |=> (!word_vld_o && rst_req_o));

endmodule

// File: tb/dual_rail_guard_test.sv
module dual_rail_guard_test;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] ra = '0, rb = '0;
    logic         tamper = 1'b0;
    logic [W-1:0] word, oa, ob;
    logic         vld, oerr, rreq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // reference state
    logic [W-1:0] m_word;
    logic         m_ready, m_alarm;

    always #2 clk = ~clk;  // 250 MHz

    dual_rail_guard #(.WIDTH(W)) uut (
        .clk(clk), .rst_n(rst_n), .rail_a_i(ra), .rail_b_i(rb), .tamper_i(tamper),
        .word_o(word), .word_vld_o(vld), .order_err_o(oerr),
        .out_a_o(oa), .out_b_o(ob), .rst_req_o(rreq)
    );

    function automatic logic [2*W-1:0] encode(input logic [W-1:0] v);
        return {v, ~v};  // {rail A, rail B}
    endfunction

    function automatic logic [4*W+2:0] pack_out(input logic [W-1:0] w, input logic v,
            input logic e, input logic [W-1:0] a, input logic [W-1:0] b, input logic r);
        return {w, v, e, a, b, r};
    endfunction

    task automatic check(input string tag, input logic [4*W+2:0] act, input logic [4*W+2:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic reset_dut();
        rst_n = 1'b0; ra = '0; rb = '0; tamper = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        m_word = '0; m_ready = 1'b1; m_alarm = 1'b0;
        // R9 reset state
        check("R9 reset", pack_out(word, vld, oerr, oa, ob, rreq),
              pack_out('0, 1'b0, 1'b0, '0, '0, 1'b0));
        rst_n = 1'b1;
    endtask

    // Apply one cycle of inputs, predict the outputs, compare after the edge.
    task automatic cycle(input logic [W-1:0] a, input logic [W-1:0] b, input logic t, input string tag);
        logic fault, full, empty, acc;
        logic [4*W+2:0] exp;
        ra = a; rb = b; tamper = t;
        fault = |(a & b);
        full  = &(a ^ b);
        empty = ~|(a | b);
        if (m_alarm || fault || t) begin
            m_alarm = 1'b1; m_ready = 1'b0; m_word = '0;
            exp = pack_out('0, 1'b0, 1'b0, {W{1'b1}}, {W{1'b1}}, 1'b1);
        end else begin
            acc = full && m_ready;
            exp = pack_out(acc ? a : m_word, acc, full && !m_ready && (a != m_word),
                           acc ? a : '0, acc ? ~a : '0, 1'b0);
            if (acc) begin m_word = a; m_ready = 1'b0; end
            else if (empty) m_ready = 1'b1;
        end
        @(posedge clk);
        #1;
        check(tag, pack_out(word, vld, oerr, oa, ob, rreq), exp);
    endtask

    task automatic send(input logic [W-1:0] v, input logic t, input string tag);
        logic [2*W-1:0] p;
        p = encode(v);
        cycle(p[2*W-1:W], p[W-1:0], t, tag);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            finish_run();
        end
    end

    initial begin : stim
        logic [2*W-1:0] p;
        int unused_seed;
        unused_seed = $urandom(32'h5EED_0042);
        reset_dut();

        // R1 decode and forward
        send(8'hA5, 1'b0, "R1 first word");
        // R3 held word: no pulse, no error
        send(8'hA5, 1'b0, "R3 held word");
        // R3 different word without spacer
        send(8'h3C, 1'b0, "R3 order error");
        cycle('0, '0, 1'b0, "R2 spacer");
        // R2 partial word: pairs 7..4 empty
        p = encode(8'h0F);
        cycle({4'h0, p[W+3:W]}, {4'h0, p[3:0]}, 1'b0, "R2 partial");
        send(8'h0F, 1'b0, "R1 after spacer");
        cycle('0, '0, 1'b0, "R2 spacer");
        // R8 rail B dropped on bit 2 -> empty pair, not valid
        p = encode(8'h00);
        cycle(p[2*W-1:W], p[W-1:0] & ~8'h04, 1'b0, "R8 rail B low flip");
        // R8 R4 rail A raised on bit 2 of a zero -> both-high, alarm
        cycle(p[2*W-1:W] | 8'h04, p[W-1:0], 1'b0, "R4 R8 rail A high flip");
        // R6 R7 alarm holds against valid traffic
        cycle('0, '0, 1'b0, "R7 sticky spacer");
        send(8'h81, 1'b0, "R6 R7 word in alarm");
        reset_dut();

        // R5 tamper with a complete word in the same cycle
        send(8'h5A, 1'b1, "R5 tamper with word");
        send(8'h11, 1'b0, "R7 after tamper");
        reset_dut();
        cycle('0, '0, 1'b1, "R5 tamper alone");
        cycle('0, '0, 1'b0, "R7 tamper released");
        reset_dut();

        // Random traffic without faults
        for (int i = 0; i < 400; i++) begin
            int kind;
            logic [W-1:0] v, m;
            kind = $urandom_range(0, 9);
            v = W'($urandom);
            m = W'($urandom);
            p = encode(v);
            if (kind < 4)      cycle('0, '0, 1'b0, "R2 rand spacer");
            else if (kind < 8) send(v, 1'b0, "R1 R3 rand word");
            else               cycle(p[2*W-1:W] & m, p[W-1:0] & m, 1'b0, "R2 rand partial");
        end

        // Random single-rail flips and tamper pulses
        for (int i = 0; i < 60; i++) begin
            logic [W-1:0] v, bitm;
            v = W'($urandom);
            bitm = W'(1) << $urandom_range(0, W-1);
            p = encode(v);
            cycle('0, '0, 1'b0, "R2 rand spacer");
            case ($urandom_range(0, 2))
                0: cycle(p[2*W-1:W] ^ bitm, p[W-1:0], 1'b0, "R8 rand rail A flip");
                1: cycle(p[2*W-1:W], p[W-1:0] ^ bitm, 1'b0, "R8 rand rail B flip");
                default: send(v, 1'b1, "R5 rand tamper");
            endcase
            send(v, 1'b0, "R7 rand follow");
            reset_dut();
        end

        done = 1'b1;
        finish_run();
    end

endmodule